// File: doc/BRIEF.md
# Sequential Multiply/Divide Register Peripheral

This block is an arithmetic helper that a small processor drives through a plain register bus. Software loads a 32-bit operand A as two 16-bit halves and a 16-bit operand B. It then writes the control register with the run bit set. The block works on the operands over several clocks and writes the result back into A. In divide mode the remainder goes to a separate read-only register. When the work is done, the block drops the run bit and raises a one-cycle completion pulse.

Multiply mode forms the 32-bit product of the low half of A and B by shift-and-add, one multiplier bit per clock, 16 clocks in all. Divide mode runs a restoring shift-subtract over 32 clocks: the quotient replaces A and the remainder is kept apart. Software can stop an operation by clearing the run bit. If that clearing write lands on the final working cycle, the result stands and the pulse still fires.

Top module: `muldiv_periph`

## Requirements
- R1: After reset, every register reads 0 and `irq_done` is low.
- R2: The register map by `bus_addr` is: 0 = A bits 15:0, 1 = A bits 31:16, 2 = B, 3 = remainder (read-only, writes ignored), 4 = control. `bus_rdata` returns the addressed register one clock after the address is presented.
- R3: In the control register, bit 7 is the run bit and bit 0 selects the mode (1 = multiply, 0 = divide). Writing bit 7 = 1 while idle starts an operation. Bit 7 reads 1 while the operation runs and 0 afterwards.
- R4: The remainder register is cleared to 0 on the clock edge that starts an operation.
- R5: A multiply start clears A bits 31:16 on the start edge. Sixteen clocks later A holds the 32-bit product of the old A bits 15:0 and B.
- R6: A divide with B not zero leaves A = A / B and remainder = A mod B after 32 clocks.
- R7: On the edge that performs the last working step, the run bit clears. `irq_done` is then high for exactly one cycle: 16 edges after the start edge for multiply, 32 for divide.
- R8: A control write with bit 7 = 0 during an operation, on any cycle other than the last working step, stops the operation. No `irq_done` pulse follows and the run bit reads 0. A later reload and start runs normally.
- R9: A control write with bit 7 = 0 on the last working step leaves the result intact and still produces the `irq_done` pulse.
- R10: A divide with B = 0 still ends after 32 clocks with an `irq_done` pulse. A and the remainder are unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall on the same clock edge: the final working step and a software stop request. The bench counts edges from the start write and places a control write with the run bit clear on exactly the sixteenth edge of a multiply. It expects the completion pulse and a correct product. It repeats the write one edge earlier and expects no pulse. A behavioural model that counts the remaining steps predicts `irq_done` and is compared on every clock, so a pulse that is early, late, missing or extra is caught beside the result checks.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    ADR_ALO  = 3'd0,
    ADR_AHI  = 3'd1,
    ADR_B    = 3'd2,
    ADR_REM  = 3'd3,
    ADR_CTRL = 3'd4
  } mdu_addr_e;

  localparam int CTRL_RUN_BIT  = 7;
  localparam int CTRL_MODE_BIT = 0;
endpackage

// File: rtl/mdu_seq.sv
module mdu_seq #(
  parameter int OPW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_we,
  input  logic wr_run,
  input  logic wr_mul,
  output logic busy,
  output logic mode_mul,
  output logic start,
  output logic step,
  output logic irq
);
  localparam int CNT_W = $clog2(2 * OPW);
  localparam logic [CNT_W-1:0] MUL_LAST = CNT_W'(OPW - 1);
  localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(2 * OPW - 1);

  logic [CNT_W-1:0] cnt;
  logic             last;
  logic             stop_req;

  assign start    = ctrl_we & wr_run & ~busy;
  assign last     = busy & (cnt == (mode_mul ? MUL_LAST : DIV_LAST));
  assign stop_req = ctrl_we & ~wr_run & busy & ~last;
  assign step     = busy & ~stop_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      mode_mul <= 1'b0;
      cnt      <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= step & last;
      if (ctrl_we) mode_mul <= wr_mul;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (step) begin
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end else if (stop_req) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdu_arith.sv
module mdu_arith #(
  parameter int OPW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_mul,
  input  logic             step,
  input  logic             mode_mul,
  input  logic [OPW-1:0]   b,
  input  logic             lo_we,
  input  logic             hi_we,
  input  logic [OPW-1:0]   wdata,
  output logic [2*OPW-1:0] a_q,
  output logic [OPW-1:0]   rem_q
);
  localparam int AW = 2 * OPW;

  logic [OPW:0]   mul_sum;
  logic [AW-1:0]  mul_next;
  logic [OPW:0]   div_trial;
  logic           div_ge;
  logic [OPW:0]   div_diff;
  logic [AW-1:0]  div_next_a;
  logic [OPW-1:0] div_next_r;

  always_comb begin
    // shift-add: upper half accumulates, lower half shifts out multiplier bits
    mul_sum  = {1'b0, a_q[AW-1:OPW]} + (a_q[0] ? {1'b0, b} : '0);
    mul_next = {mul_sum, a_q[OPW-1:1]};
    // restoring step: bring in the next dividend bit, subtract if it fits
    div_trial  = {rem_q, a_q[AW-1]};
    div_ge     = div_trial >= {1'b0, b};
    div_diff   = div_trial - {1'b0, b};
    div_next_r = div_ge ? div_diff[OPW-1:0] : div_trial[OPW-1:0];
    div_next_a = {a_q[AW-2:0], div_ge};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      rem_q <= '0;
    end else begin
      if (start) begin
        rem_q <= '0;
        if (start_mul) a_q[AW-1:OPW] <= '0;
      end else if (step) begin
        if (mode_mul) begin
          a_q <= mul_next;
        end else begin
          a_q   <= div_next_a;
          rem_q <= div_next_r;
        end
      end
      if (lo_we) a_q[OPW-1:0]  <= wdata;
      if (hi_we) a_q[AW-1:OPW] <= wdata;
    end
  end
endmodule

// File: rtl/muldiv_periph.sv
module muldiv_periph #(
  parameter int OPW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_we,
  input  logic [2:0]     bus_addr,
  input  logic [OPW-1:0] bus_wdata,
  output logic [OPW-1:0] bus_rdata,
  output logic           irq_done
);
  import mdu_pkg::*;

  localparam int AW = 2 * OPW;

  logic           busy, mode_mul, start, step;
  logic           ctrl_we, lo_we, hi_we, b_we;
  logic [OPW-1:0] b_q;
  logic [AW-1:0]  a_q;
  logic [OPW-1:0] rem_q;

  assign ctrl_we = bus_we & (bus_addr == ADR_CTRL);
  assign lo_we   = bus_we & (bus_addr == ADR_ALO);
  assign hi_we   = bus_we & (bus_addr == ADR_AHI);
  assign b_we    = bus_we & (bus_addr == ADR_B);

  always_ff @(posedge clk) begin
    if (rst) b_q <= '0;
    else if (b_we) b_q <= bus_wdata;
  end

  mdu_seq #(.OPW(OPW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .ctrl_we  (ctrl_we),
    .wr_run   (bus_wdata[CTRL_RUN_BIT]),
    .wr_mul   (bus_wdata[CTRL_MODE_BIT]),
    .busy     (busy),
    .mode_mul (mode_mul),
    .start    (start),
    .step     (step),
    .irq      (irq_done)
  );

  mdu_arith #(.OPW(OPW)) u_arith (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .start_mul (bus_wdata[CTRL_MODE_BIT]),
    .step      (step),
    .mode_mul  (mode_mul),
    .b         (b_q),
    .lo_we     (lo_we),
    .hi_we     (hi_we),
    .wdata     (bus_wdata),
    .a_q       (a_q),
    .rem_q     (rem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      case (bus_addr)
        ADR_ALO:  bus_rdata <= a_q[OPW-1:0];
        ADR_AHI:  bus_rdata <= a_q[AW-1:OPW];
        ADR_B:    bus_rdata <= b_q;
        ADR_REM:  bus_rdata <= rem_q;
        ADR_CTRL: begin
          bus_rdata[CTRL_RUN_BIT]  <= busy;
          bus_rdata[CTRL_MODE_BIT] <= mode_mul;
        end
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int OPW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_we,
  input logic [2:0]       bus_addr,
  input logic [OPW-1:0]   bus_wdata,
  input logic             busy,
  input logic             mode_mul,
  input logic [2*OPW-1:0] a_q,
  input logic [OPW-1:0]   rem_q,
  input logic             irq_done
);
  localparam int RUN_W = $clog2(2 * OPW) + 2;

  logic [RUN_W-1:0] run_cnt;
  logic             stop_wr;

  assign stop_wr = bus_we && (bus_addr == mdu_pkg::ADR_CTRL) &&
                   !bus_wdata[mdu_pkg::CTRL_RUN_BIT];

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else run_cnt <= run_cnt + 1'b1;
  end

  AST_REM_CLEARED_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (rem_q == '0)); // R4

  AST_MUL_HI_CLEARED: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && mode_mul) |-> (a_q[2*OPW-1:OPW] == '0)); // R5

  AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done); // R7

  AST_IRQ_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> (!busy && $past(busy))); // R7

  AST_STOP_WRITE_HALTS: assert property (@(posedge clk) disable iff (rst)
    (stop_wr && busy) |=> !busy); // R8

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= RUN_W'(2 * OPW)); // R10
endmodule

bind muldiv_periph mdu_checker #(.OPW(OPW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .busy      (busy),
  .mode_mul  (mode_mul),
  .a_q       (a_q),
  .rem_q     (rem_q),
  .irq_done  (irq_done)
);

// File: tb/tb_muldiv_periph.sv
`timescale 1ns/1ps
module tb_muldiv_periph;
  localparam logic [2:0] A_LO = 3'd0, A_HI = 3'd1, B_R = 3'd2, REM_R = 3'd3, CTL = 3'd4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq_done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  muldiv_periph dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_done(irq_done)
  );

  // behavioural model of run state: steps remaining and expected pulse
  bit m_busy = 0;
  int m_left = 0;
  bit m_irq  = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_left <= 0; m_irq <= 0;
    end else begin
      m_irq <= 0;
      if (bus_we && bus_addr == CTL && bus_wdata[7] && !m_busy) begin
        m_busy <= 1;
        m_left <= bus_wdata[0] ? 16 : 32;
      end else if (m_busy) begin
        if (m_left == 1) begin
          m_busy <= 0; m_irq <= 1;
        end else if (bus_we && bus_addr == CTL && !bus_wdata[7]) begin
          m_busy <= 0;
        end else begin
          m_left <= m_left - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) chk(irq_done === m_irq, "R7 irq_done vs model", {31'd0, irq_done}, {31'd0, m_irq});
  end

  task automatic wr(input logic [2:0] ad, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = ad; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ad, output logic [15:0] v);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = ad;
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_irq(input int maxc, output bit seen);
    seen = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (irq_done) begin seen = 1; break; end
    end
  endtask

  task automatic run_mul(input logic [15:0] alo, input logic [15:0] ahi, input logic [15:0] b);
    logic [15:0] v, lo, hi;
    bit seen;
    logic [31:0] exp;
    exp = alo * b;
    wr(A_LO, alo); wr(A_HI, ahi); wr(B_R, b);
    wr(CTL, 16'h0081);
    rd(A_HI, v);
    chk(v == 16'd0, "R5 A high cleared at start", {16'd0, v}, 32'd0);
    rd(CTL, v);
    chk(v[7] == 1'b1, "R3 run bit set while busy", {16'd0, v}, 32'h81);
    wait_irq(40, seen);
    chk(seen, "R7 multiply completion pulse", {31'd0, seen}, 32'd1);
    rd(A_LO, lo); rd(A_HI, hi);
    chk({hi, lo} == exp, "R5 product", {hi, lo}, exp);
    rd(CTL, v);
    chk(v[7] == 1'b0, "R3 run bit cleared after done", {16'd0, v}, 32'h01);
  endtask

  task automatic run_div(input logic [31:0] a, input logic [15:0] b);
    logic [15:0] v, lo, hi, r;
    bit seen;
    logic [31:0] q, rm;
    q = a / b; rm = a % b;
    wr(A_LO, a[15:0]); wr(A_HI, a[31:16]); wr(B_R, b);
    wr(CTL, 16'h0080);
    rd(REM_R, v);
    chk(v == 16'd0, "R4 remainder cleared at start", {16'd0, v}, 32'd0);
    wait_irq(40, seen);
    chk(seen, "R7 divide completion pulse", {31'd0, seen}, 32'd1);
    rd(A_LO, lo); rd(A_HI, hi); rd(REM_R, r);
    chk({hi, lo} == q, "R6 quotient", {hi, lo}, q);
    chk({16'd0, r} == rm, "R6 remainder", {16'd0, r}, rm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, lo, hi;
    bit seen;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    for (int ad = 0; ad < 5; ad++) begin
      rd(ad[2:0], v);
      chk(v == 16'd0, "R1 reset register value", {16'd0, v}, 32'd0);
    end
    chk(irq_done == 1'b0, "R1 irq low after reset", {31'd0, irq_done}, 32'd0);

    // R2 remainder register ignores writes; B reads back
    wr(REM_R, 16'hBEEF);
    rd(REM_R, v);
    chk(v == 16'd0, "R2 remainder write ignored", {16'd0, v}, 32'd0);
    wr(B_R, 16'h1234);
    rd(B_R, v);
    chk(v == 16'h1234, "R2 B readback", {16'd0, v}, 32'h1234);

    // R5 multiply with several patterns
    run_mul(16'hFFFF, 16'hAAAA, 16'hFFFF);
    run_mul(16'h0000, 16'h5555, 16'h1234);
    for (int i = 0; i < 3; i++) run_mul(16'($urandom), 16'($urandom), 16'($urandom));

    // R6 divide with several patterns (remainder nonzero before start for R4)
    run_div(32'hFFFF_FFFF, 16'h0007);
    run_div(32'h0000_0005, 16'hFFFF);
    for (int i = 0; i < 3; i++) run_div($urandom, 16'($urandom % 65535) + 16'd1);

    // R10 divide by zero terminates
    wr(A_LO, 16'h1357); wr(A_HI, 16'h2468); wr(B_R, 16'h0000);
    wr(CTL, 16'h0080);
    wait_irq(40, seen);
    chk(seen, "R10 divide by zero terminates", {31'd0, seen}, 32'd1);

    // R8 abort mid divide: no pulse, run bit clear
    wr(A_LO, 16'h4321); wr(A_HI, 16'h8765); wr(B_R, 16'h0033);
    wr(CTL, 16'h0080);
    repeat (5) @(posedge clk);
    wr(CTL, 16'h0000);
    wait_irq(40, seen);
    chk(!seen, "R8 no pulse after abort", {31'd0, seen}, 32'd0);
    rd(CTL, v);
    chk(v[7] == 1'b0, "R8 run bit clear after abort", {16'd0, v}, 32'd0);

    // R8 abort one edge before the last step of a multiply
    wr(A_LO, 16'h00FF); wr(A_HI, 16'h0000); wr(B_R, 16'h0101);
    wr(CTL, 16'h0081);
    repeat (14) @(posedge clk);
    wr(CTL, 16'h0001);
    wait_irq(40, seen);
    chk(!seen, "R8 abort on second-to-last step", {31'd0, seen}, 32'd0);

    // R8 reload and restart after abort
    run_mul(16'h0F0F, 16'h0000, 16'h00F0);

    // R9 stop write on the final step: result stands, pulse fires
    wr(A_LO, 16'hC0DE); wr(A_HI, 16'h1111); wr(B_R, 16'h0ABC);
    wr(CTL, 16'h0081);
    repeat (15) @(posedge clk);
    wr(CTL, 16'h0001);
    wait_irq(3, seen);
    chk(seen, "R9 pulse when stop meets completion", {31'd0, seen}, 32'd1);
    rd(A_LO, lo); rd(A_HI, hi);
    chk({hi, lo} == 32'hC0DE * 32'h0ABC, "R9 product kept", {hi, lo}, 32'hC0DE * 32'h0ABC);

    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule